// File: doc/BRIEF.md
# Video Memory Indirect Access Port

This block gives a byte-wide CPU bus indirect access to a video memory of 16-bit words. The CPU never addresses the memory directly. It writes a register number to the index port. It then moves bytes to and from the selected 16-bit register through two data ports, one for the low byte and one for the high byte. Four registers exist: a write pointer, a read pointer, a data window and a control word. Bits [12:11] of the control word choose how far both pointers move after each word.

Every word-level side effect is tied to the high byte. A low-byte data write is only held in a latch. The following high-byte write stores both bytes as one word and moves the write pointer. A new read pointer is staged byte by byte and takes effect on its high byte. That high byte also starts a prefetch into a read buffer. Reading the high byte of the data window returns the buffered word's upper half, then moves the read pointer and prefetches again. With step codes of 32 and more, one tilemap column fills with no pointer rewrites.

The CPU side is two valid/ready channels. A request carries a port code, a direction and a byte. Only a read produces a response, which carries one byte. The block accepts a request only when no response is waiting and no prefetch is in flight, so exactly one read is outstanding at any time. A stalled response holds its data until it is taken. Pointers are 15 bits wide. The array decodes the low `MEM_AW` bits of a pointer; set `MEM_AW` to 15 for the full 32K-word memory.

Top module: `vram_port`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and the index, both pointers, the control word and the read buffer all read as zero.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. Each taken read gives exactly one response, valid from the next cycle. The response holds its data until rsp_ready is seen, and req_ready stays 0 while the response is pending.
- R3: A write to port code 0 (index port) selects register number wdata[4:0]. A read of port code 0 returns that number, zero-extended.
- R4: With register 02h selected, a write to port code 2 (low byte) only latches the byte, and leaves the memory and the write pointer unchanged. A write to port code 3 (high byte) stores {high, latched low} at the write pointer and then adds the step to the write pointer.
- R5: With register 01h selected, a low-byte write is staged and does not change the read pointer as read back. The high-byte write commits {high, staged low}, prefetches that word, and holds req_ready at 0 for the next cycle.
- R6: With register 02h selected, a low-byte read returns the buffered word's low byte and moves nothing. A high-byte read returns its high byte, then adds the step to the read pointer and prefetches the word at the new pointer.
- R7: The step comes from control bits [12:11]. Code 0 gives 1, code 1 gives 32, code 2 gives 64 and code 3 gives 128.
- R8: Low and high reads of register 00h, 01h and 05h return the matching byte of the write pointer, the committed read pointer and the control word. Any other register number, and port code 1 in either direction, reads as 0 and has no effect.
- R9: Both pointers are 15 bits wide and wrap modulo 2^15 when they advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_port | input | 2 | Port code: 0 index, 1 unused, 2 data low byte, 3 data high byte |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response byte |

## Verification
A read response is registered on the edge that takes the request, so it is visible one cycle later. It then remains until the first edge where rsp_ready is high, and rsp_ready is withheld on a fixed cycle pattern to exercise the hold. A read-pointer commit or a high-byte data read lowers req_ready for exactly the next cycle while the prefetch lands. The bench checks that drop at the falling edge that follows the accepting edge. Expected bytes are queued when a read is issued. A monitor pops one on each falling edge where the response is being handed over, so ordering and latency are checked without counting cycles in the driver.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  localparam int IDX_W  = 5;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  // port codes on req_port
  localparam logic [1:0] PORT_INDEX = 2'd0;
  localparam logic [1:0] PORT_NONE  = 2'd1;
  localparam logic [1:0] PORT_LO    = 2'd2;
  localparam logic [1:0] PORT_HI    = 2'd3;

  // internal register numbers
  localparam logic [IDX_W-1:0] IDX_WPTR = 5'h00;
  localparam logic [IDX_W-1:0] IDX_RPTR = 5'h01;
  localparam logic [IDX_W-1:0] IDX_DATA = 5'h02;
  localparam logic [IDX_W-1:0] IDX_CTRL = 5'h05;

  // step code -> pointer increment: 0->1, n->16<<n
  function automatic logic [7:0] step_of(input logic [1:0] code);
    return (code == 2'd0) ? 8'd1 : (8'd16 << code);
  endfunction

endpackage

// File: rtl/vram_port_mem.sv
module vram_port_mem #(
  parameter int MEM_AW = 11
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [MEM_AW-1:0]                   waddr,
  input  logic [vram_port_pkg::WORD_W-1:0]    wdata,
  input  logic                                re,
  input  logic [MEM_AW-1:0]                   raddr,
  output logic [vram_port_pkg::WORD_W-1:0]    rbuf
);
  import vram_port_pkg::*;

  localparam int DEPTH = 1 << MEM_AW;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // read buffer doubles as the prefetch register
  always_ff @(posedge clk) begin
    if (!rst_n)  rbuf <= '0;
    else if (re) rbuf <= store[raddr];
  end

endmodule

// File: rtl/vram_port_regs.sv
module vram_port_regs #(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic                     is_wr,
  input  logic [1:0]               port,
  input  logic [7:0]               wbyte,
  input  logic [15:0]              rbuf,
  output logic [7:0]               rbyte,
  output logic                     mem_we,
  output logic [MEM_AW-1:0]        mem_waddr,
  output logic [15:0]              mem_wdata,
  output logic                     pf_busy,
  output logic [MEM_AW-1:0]        pf_addr,
  output logic [4:0]               cur_idx,
  output logic [ADDR_W-1:0]        cur_wptr
);
  import vram_port_pkg::*;

  localparam int HI_W = ADDR_W - BYTE_W;

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic [7:0]        rlo_q, wlat_q;
  logic [15:0]       ctrl_q;
  logic              pf_q;
  logic [ADDR_W-1:0] step;
  logic              do_wr, do_rd;
  logic [15:0]       sel_word;

  assign step  = ADDR_W'(step_of(ctrl_q[12:11]));
  assign do_wr = take &  is_wr;
  assign do_rd = take & ~is_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      rlo_q  <= '0;
      wlat_q <= '0;
      ctrl_q <= '0;
      pf_q   <= 1'b0;
    end else begin
      pf_q <= 1'b0;
      if (do_wr) begin
        case (port)
          PORT_INDEX: idx_q <= wbyte[IDX_W-1:0];
          PORT_LO: begin
            case (idx_q)
              IDX_WPTR: wptr_q[BYTE_W-1:0] <= wbyte;
              IDX_RPTR: rlo_q <= wbyte;
              IDX_DATA: wlat_q <= wbyte;
              IDX_CTRL: ctrl_q[7:0] <= wbyte;
              default: ;
            endcase
          end
          PORT_HI: begin
            case (idx_q)
              IDX_WPTR: wptr_q[ADDR_W-1:BYTE_W] <= wbyte[HI_W-1:0];
              IDX_RPTR: begin
                rptr_q <= {wbyte[HI_W-1:0], rlo_q};
                pf_q   <= 1'b1;
              end
              IDX_DATA: wptr_q <= wptr_q + step;
              IDX_CTRL: ctrl_q[15:8] <= wbyte;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
      if (do_rd && port == PORT_HI && idx_q == IDX_DATA) begin
        rptr_q <= rptr_q + step;
        pf_q   <= 1'b1;
      end
    end
  end

  assign mem_we    = do_wr && port == PORT_HI && idx_q == IDX_DATA;
  assign mem_waddr = wptr_q[MEM_AW-1:0];
  assign mem_wdata = {wbyte, wlat_q};
  assign pf_busy   = pf_q;
  assign pf_addr   = rptr_q[MEM_AW-1:0];
  assign cur_idx   = idx_q;
  assign cur_wptr  = wptr_q;

  always_comb begin
    case (idx_q)
      IDX_WPTR: sel_word = 16'(wptr_q);
      IDX_RPTR: sel_word = 16'(rptr_q);
      IDX_DATA: sel_word = rbuf;
      IDX_CTRL: sel_word = ctrl_q;
      default:  sel_word = '0;
    endcase
    case (port)
      PORT_INDEX: rbyte = 8'(idx_q);
      PORT_LO:    rbyte = sel_word[7:0];
      PORT_HI:    rbyte = sel_word[15:8];
      default:    rbyte = '0;
    endcase
  end

endmodule

// File: rtl/vram_port.sv
module vram_port #(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_port,
  input  logic       req_write,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data
);

  logic              take;
  logic [7:0]        rbyte;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr, pf_addr;
  logic [15:0]       mem_wdata, rbuf;
  logic              pf_busy;
  logic [4:0]        cur_idx;
  logic [ADDR_W-1:0] cur_wptr;
  logic              rv_q;
  logic [7:0]        rd_q;

  assign req_ready = ~rv_q & ~pf_busy;
  assign take      = req_valid & req_ready;

  vram_port_regs #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .is_wr    (req_write),
    .port     (req_port),
    .wbyte    (req_wdata),
    .rbuf     (rbuf),
    .rbyte    (rbyte),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata),
    .pf_busy  (pf_busy),
    .pf_addr  (pf_addr),
    .cur_idx  (cur_idx),
    .cur_wptr (cur_wptr)
  );

  vram_port_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .re   (pf_busy),
    .raddr(pf_addr),
    .rbuf (rbuf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else if (take && !req_write) begin
      rv_q <= 1'b1;
      rd_q <= rbyte;
    end else if (rv_q && rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_port,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic [4:0]        cur_idx,
  input logic [ADDR_W-1:0] cur_wptr
);

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  logic take;
  assign take = req_valid & req_ready;

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_rsp_from_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(rsp_valid) |-> $past(take && !req_write));

  assert_prefetch_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_write && req_port == 2'd3 && cur_idx == 5'h01 |=> !req_ready);

  assert_wptr_moves_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cur_wptr != $past(cur_wptr) |->
      $past(take && req_write && req_port[1] &&
            (cur_idx == 5'h00 || (cur_idx == 5'h02 && req_port[0]))));

endmodule

bind vram_port vram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_port (req_port),
  .req_write(req_write),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .cur_idx  (cur_idx),
  .cur_wptr (cur_wptr)
);

// File: tb/vram_port_bench.sv
module vram_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_port = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  vram_port u_vram_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_port(req_port), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // consumer back-pressure pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_ready <= (cyc % 4 != 2);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on each handed-over response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", rsp_data, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic issue(input logic [1:0] p, input logic w, input logic [7:0] d);
    @(negedge clk);
    req_port = p; req_write = w; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    issue(p, 1'b1, d);
  endtask

  task automatic rd(input logic [1:0] p, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issue(p, 1'b0, 8'h00);
  endtask

  task automatic set16(input logic [4:0] i, input logic [15:0] v);
    wr(2'd0, 8'(i));
    wr(2'd2, v[7:0]);
    wr(2'd3, v[15:8]);
  endtask

  task automatic read16(input logic [4:0] i, input logic [15:0] e, input string tag);
    wr(2'd0, 8'(i));
    rd(2'd2, e[7:0], tag);
    rd(2'd3, e[15:8], tag);
  endtask

  task automatic put_word(input logic [15:0] v);
    wr(2'd2, v[7:0]);
    wr(2'd3, v[15:8]);
  endtask

  task automatic get_word(input logic [15:0] e, input string tag);
    rd(2'd2, e[7:0], tag);
    rd(2'd3, e[15:8], tag);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    rd(2'd0, 8'h00, "R1 index after reset");
    read16(5'h00, 16'h0000, "R1 write pointer after reset");
    read16(5'h01, 16'h0000, "R1 read pointer after reset");
    read16(5'h05, 16'h0000, "R1 control after reset");
    wr(2'd0, 8'h02);
    rd(2'd2, 8'h00, "R1 read buffer after reset");

    // R4 commit on high byte, step 1
    set16(5'h05, 16'h0000);
    set16(5'h00, 16'h0010);
    wr(2'd0, 8'h02);
    put_word(16'h1234);
    put_word(16'h5678);
    wr(2'd2, 8'hAA);
    read16(5'h00, 16'h0012, "R4 low write leaves pointer");
    wr(2'd0, 8'h02);
    wr(2'd3, 8'hBB);
    read16(5'h00, 16'h0013, "R4 high write advances pointer");

    // R5 staged read pointer
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h10);
    rd(2'd2, 8'h00, "R5 staged low not visible");
    rd(2'd3, 8'h00, "R5 staged low not visible");
    wr(2'd3, 8'h00);
    check(req_ready == 1'b0, "R5 prefetch stall", req_ready, 0);
    read16(5'h01, 16'h0010, "R5 committed read pointer");

    // R6 reads
    wr(2'd0, 8'h02);
    rd(2'd2, 8'h34, "R6 low read");
    rd(2'd2, 8'h34, "R6 repeated low read no advance");
    rd(2'd3, 8'h12, "R6 high read");
    get_word(16'h5678, "R6 second word");
    get_word(16'hBBAA, "R4 latched low joined with high");
    read16(5'h01, 16'h0013, "R6 read pointer advanced");

    // R7 step codes on writes
    set16(5'h05, 16'h0800);
    read16(5'h05, 16'h0800, "R8 control readback");
    set16(5'h00, 16'h0100);
    wr(2'd0, 8'h02);
    put_word(16'hC001); put_word(16'hC002); put_word(16'hC003);
    read16(5'h00, 16'h0160, "R7 step 32");
    set16(5'h05, 16'h1000);
    set16(5'h00, 16'h0200);
    wr(2'd0, 8'h02);
    put_word(16'hD001); put_word(16'hD002);
    read16(5'h00, 16'h0280, "R7 step 64");
    set16(5'h05, 16'h1800);
    set16(5'h00, 16'h0300);
    wr(2'd0, 8'h02);
    put_word(16'hE001); put_word(16'hE002);
    read16(5'h00, 16'h0400, "R7 step 128");

    // R7 step codes on reads
    set16(5'h05, 16'h1000);
    set16(5'h01, 16'h0200);
    wr(2'd0, 8'h02);
    get_word(16'hD001, "R7 read step 64");
    get_word(16'hD002, "R7 read step 64");
    read16(5'h01, 16'h0280, "R7 read pointer step 64");
    set16(5'h05, 16'h0800);
    set16(5'h01, 16'h0100);
    wr(2'd0, 8'h02);
    get_word(16'hC001, "R7 read step 32");
    get_word(16'hC002, "R7 read step 32");
    get_word(16'hC003, "R7 read step 32");
    set16(5'h05, 16'h1800);
    set16(5'h01, 16'h0300);
    wr(2'd0, 8'h02);
    get_word(16'hE001, "R7 read step 128");
    get_word(16'hE002, "R7 read step 128");

    // R9 wrap
    set16(5'h05, 16'h0000);
    set16(5'h00, 16'h7FFF);
    wr(2'd0, 8'h02);
    put_word(16'hA55A);
    read16(5'h00, 16'h0000, "R9 write pointer wraps");
    set16(5'h01, 16'h7FFF);
    wr(2'd0, 8'h02);
    get_word(16'hA55A, "R9 word at top address");
    read16(5'h01, 16'h0000, "R9 read pointer wraps");

    // R3 / R8 index and unused codes
    wr(2'd0, 8'h03);
    rd(2'd0, 8'h03, "R3 index readback");
    rd(2'd2, 8'h00, "R8 unused register low");
    rd(2'd3, 8'h00, "R8 unused register high");
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h00, "R8 port code 1 reads zero");
    rd(2'd0, 8'h03, "R8 port code 1 write ignored");
    wr(2'd0, 8'h05);
    rd(2'd0, 8'h05, "R3 index reselect");
    read16(5'h00, 16'h0000, "R8 write pointer untouched");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule